// File: doc/BRIEF.md
# Address-Masked Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port attached to a simple word-addressed register bus. Each pin has a direction bit, where 1 means output and 0 means input. The port's data register sits in a window of byte offsets. The access address carries a per-pin mask, so software can read or write a single pin, or any subset of pins, in one bus access. It never needs a read-modify-write sequence.

Pins set as inputs are sampled through a two-flop synchronizer and fed into the data register. Pins set as outputs take their value from bus writes. Every pin configured as an input presents a high level on its output value. The current data and direction words are also brought out so that an external interrupt detector can watch them. A fixed block of twelve identification bytes can be read at the top of the address space. Any other offset reads as zero and ignores writes.

The bus is a single-cycle interface. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low, and it is zero otherwise. Address bits [1:0] are ignored.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, the data register and the direction register are 0x00, and `pin_out` is 0xFF.
- R2: A read at any offset below 0x400 returns the data register ANDed with the mask formed by address bits [9:2], zero-extended to 32 bits.
- R3: A write at an offset below 0x400 changes exactly those data bits whose address-mask bit (address bits [9:2]) and direction bit are both 1. Each such bit takes the corresponding bit of `bus_wdata[7:0]`.
- R4: The direction register lives at offset 0x400, with 1 meaning output. A write loads `bus_wdata[7:0]`, and a read returns it zero-extended.
- R5: For a pin whose direction bit is 0, the data bit takes the level of `pin_in`. A level applied before a clock edge appears in the data register after the third rising edge, and not after the second. For a pin whose direction bit is 1, `pin_in` has no effect.
- R6: Each bit of `pin_out` is 1 if the pin is an input, and otherwise equals the data bit.
- R7: A read at offset 0xFD0 + 4*k, for k from 0 to 11, returns byte k of the sequence 0x00,0x00,0x00,0x00,0x61,0x10,0x04,0x00,0x0D,0xF0,0x05,0xB1, zero-extended.
- R8: Reads of offsets from 0x404 to 0xFCC return zero. Writes there change neither the data register nor the direction register.
- R9: `port_data` and `port_dir` always equal the values that a full-mask data read (offset 0x3FC) and a direction read return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; bits [7:0] used |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| port_data | output | 8 | Current data register, for the interrupt detector |
| port_dir | output | 8 | Current direction register, for the interrupt detector |

## Verification
A corrupted direction bit shows at the ports immediately: `pin_out` flips between the data value and a forced high, and a masked write either lands or misses on the next edge. A wrong data bit is visible at once on `port_data` and through any read whose mask covers it. A broken synchronizer shows up as an input change that arrives one edge early or late. The bench therefore samples input propagation on both sides of the third edge, and checks every masked access against the bits the mask excludes.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
  parameter int unsigned GPIO_W   = 8;
  parameter int unsigned BUS_W    = 32;
  parameter int unsigned OFS_W    = 12;
  parameter int unsigned SYNC_LEN = 2;
  parameter int unsigned ID_CNT   = 12;

  // Identification byte k of the fixed sequence.
  function automatic logic [7:0] ident_byte(input int unsigned k);
    case (k)
      4:       return 8'h61;
      5:       return 8'h10;
      6:       return 8'h04;
      8:       return 8'h0D;
      9:       return 8'hF0;
      10:      return 8'h05;
      11:      return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_hit,
  input  logic         wr_dir_hit,
  input  logic [W-1:0] acc_mask,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] in_sync,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (wr_dir_hit) dir_q <= wr_val;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q[i] <= 1'b0;
        else if (!dir_q[i]) data_q[i] <= in_sync[i];
        else if (wr_data_hit && acc_mask[i]) data_q[i] <= wr_val[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_mp_rdmux.sv
module gpio_mp_rdmux #(
  parameter int unsigned W      = 8,
  parameter int unsigned BW     = 32,
  parameter int unsigned AW     = 12,
  parameter int unsigned ID_CNT = 12
) (
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  data_q,
  input  logic [W-1:0]  dir_q,
  output logic [BW-1:0] rdata
);
  localparam int unsigned WIN_TOP = W + 2;
  localparam int unsigned DIR_OFS = 1 << WIN_TOP;
  localparam int unsigned ID_BASE = (1 << AW) - 4 * ID_CNT;

  function automatic logic [W-1:0] win_mask(input logic [AW-1:0] a);
    return a[WIN_TOP-1:2];
  endfunction

  logic [AW-3:0] word_idx;
  assign word_idx = addr[AW-1:2];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (int'(addr) < DIR_OFS)
        rdata[W-1:0] = data_q & win_mask(addr);
      else if (int'(word_idx) == DIR_OFS / 4)
        rdata[W-1:0] = dir_q;
      else if (int'(addr) >= ID_BASE)
        rdata[7:0] = gpio_mp_pkg::ident_byte(int'(word_idx) - ID_BASE / 4);
    end
  end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int unsigned PIN_W  = gpio_mp_pkg::GPIO_W,
  parameter int unsigned DATA_W = gpio_mp_pkg::BUS_W,
  parameter int unsigned ADDR_W = gpio_mp_pkg::OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  port_data,
  output logic [PIN_W-1:0]  port_dir
);
  localparam int unsigned WIN_TOP = PIN_W + 2;
  localparam int unsigned DIR_OFS = 1 << WIN_TOP;

  function automatic logic [PIN_W-1:0] drive_level(input logic [PIN_W-1:0] d,
                                                    input logic [PIN_W-1:0] o);
    return (d & o) | ~o;
  endfunction

  logic              wr_data_hit;
  logic              wr_dir_hit;
  logic [PIN_W-1:0]  acc_mask;
  logic [PIN_W-1:0]  in_sync;
  logic [PIN_W-1:0]  data_q;
  logic [PIN_W-1:0]  dir_q;
  logic              unused_bits;

  assign acc_mask    = bus_addr[WIN_TOP-1:2];
  assign wr_data_hit = bus_sel && bus_wr && (int'(bus_addr) < DIR_OFS);
  assign wr_dir_hit  = bus_sel && bus_wr && (int'(bus_addr[ADDR_W-1:2]) == DIR_OFS / 4);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PIN_W]};

  gpio_mp_sync #(.W(PIN_W), .STAGES(gpio_mp_pkg::SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(in_sync)
  );

  gpio_mp_regs #(.W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data_hit(wr_data_hit), .wr_dir_hit(wr_dir_hit),
    .acc_mask(acc_mask), .wr_val(bus_wdata[PIN_W-1:0]), .in_sync(in_sync),
    .data_q(data_q), .dir_q(dir_q)
  );

  gpio_mp_rdmux #(.W(PIN_W), .BW(DATA_W), .AW(ADDR_W), .ID_CNT(gpio_mp_pkg::ID_CNT)) u_rd (
    .rd_en(bus_sel && !bus_wr), .addr(bus_addr), .data_q(data_q), .dir_q(dir_q),
    .rdata(bus_rdata)
  );

  assign pin_out   = drive_level(data_q, dir_q);
  assign port_data = data_q;
  assign port_dir  = dir_q;
endmodule

// File: rtl/gpio_mp_chk.sv
module gpio_mp_chk #(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  port_data,
  input logic [PIN_W-1:0]  port_dir,
  input logic              wr_data_hit,
  input logic              wr_dir_hit,
  input logic [PIN_W-1:0]  acc_mask,
  input logic [PIN_W-1:0]  in_sync
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (port_data == '0 && port_dir == '0));

  a_r2_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr < 12'h400) |->
      ((bus_rdata[PIN_W-1:0] & ~bus_addr[PIN_W+1:2]) == '0 && bus_rdata[DATA_W-1:PIN_W] == '0));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> ((port_data & $past(port_dir) & $past(acc_mask)) ==
                     ($past(bus_wdata[PIN_W-1:0]) & $past(port_dir) & $past(acc_mask))));

  a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((port_data ^ $past(port_data)) & $past(port_dir) &
               ~($past(acc_mask) & {PIN_W{$past(wr_data_hit)}})) == '0));

  a_r4_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_hit |=> (port_dir == $past(bus_wdata[PIN_W-1:0])));

  a_r5_inputs_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((port_data & ~$past(port_dir)) == ($past(in_sync) & ~$past(port_dir))));

  a_r6_inputs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((~port_dir & ~pin_out) == '0));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr >= 12'h404 && bus_addr < 12'hFD0) |-> (bus_rdata == '0));
endmodule

bind gpio_masked_port gpio_mp_chk #(.PIN_W(PIN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .port_data(port_data),
  .port_dir(port_dir), .wr_data_hit(wr_data_hit), .wr_dir_hit(wr_dir_hit),
  .acc_mask(acc_mask), .in_sync(in_sync)
);

// File: tb/gpio_masked_port_tb_top.sv
module gpio_masked_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, port_data, port_dir;
  int checks = 0;
  int errors = 0;
  logic [7:0] id_tab [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                              8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #2 clk = ~clk;

  gpio_masked_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .port_data(port_data), .port_dir(port_dir)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 data", 32'(port_data), 32'h00);
    chk("R1 dir", 32'(port_dir), 32'h00);
    chk("R1 pin_out", 32'(pin_out), 32'hFF);
    bus_read(12'h3FC, v); chk("R1 data read", v, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    bus_write(12'h400, 32'hFFFF_FFF0);
    bus_read(12'h400, v); chk("R4 dir read", v, 32'hF0);
    chk("R9 port_dir", 32'(port_dir), v);
    chk("R6 pin_out inputs high", 32'(pin_out), 32'h0F);
  endtask

  task automatic t_write_masked();
    logic [31:0] v;
    bus_write(12'h3FC, 32'hA5);
    chk("R3 full-mask write", 32'(port_data), 32'hA0);
    chk("R6 pin_out mixed", 32'(pin_out), 32'hAF);
    bus_write(12'h0C0, 32'h00);
    chk("R3 mask 0x30 write", 32'(port_data), 32'h80);
    bus_write(12'h03C, 32'hFF);
    chk("R3 input pins not written", 32'(port_data), 32'h80);
    bus_write(12'h000, 32'hFF);
    chk("R3 zero mask write", 32'(port_data), 32'h80);
    bus_read(12'h3FF, v); chk("R9 port_data vs read", 32'(port_data), v);
  endtask

  task automatic t_read_masked();
    logic [31:0] v;
    bus_read(12'h200, v); chk("R2 read mask 0x80", v, 32'h80);
    bus_read(12'h100, v); chk("R2 read mask 0x40", v, 32'h00);
    bus_read(12'h281, v); chk("R2 read mask 0xA0", v, 32'h80);
  endtask

  task automatic t_inputs();
    logic [31:0] v;
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); @(negedge clk);
    chk("R5 not yet after two edges", 32'(port_data), 32'h80);
    @(negedge clk);
    chk("R5 inputs after three edges", 32'(port_data), 32'h8A);
    bus_read(12'h3FC, v); chk("R5 output pins ignore pin_in", v, 32'h8A);
    chk("R6 pin_out", 32'(pin_out), 32'h8F);
    bus_write(12'h400, 32'h00);
    @(negedge clk);
    chk("R5 all inputs", 32'(port_data), 32'h5A);
    chk("R6 all inputs high", 32'(pin_out), 32'hFF);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    for (int k = 0; k < 12; k++) begin
      bus_read(12'(12'hFD0 + 4 * k), v);
      chk($sformatf("R7 id byte %0d", k), v, 32'(id_tab[k]));
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(12'h404, 32'hFF);
    bus_write(12'h800, 32'hFF);
    bus_write(12'hFCC, 32'hFF);
    chk("R8 dir untouched", 32'(port_dir), 32'h00);
    chk("R8 data untouched", 32'(port_data), 32'h5A);
    bus_read(12'h404, v); chk("R8 read 0x404", v, 32'h0);
    bus_read(12'h800, v); chk("R8 read 0x800", v, 32'h0);
    bus_read(12'hFCC, v); chk("R8 read 0xFCC", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_write_masked();
    t_read_masked();
    t_inputs();
    t_ident();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule